// File: doc/BRIEF.md
# Serial CRC Receive Checker

This block validates a received codeword one bit per clock. The codeword is the message followed by its check bits, most significant bit first. An n-bit register divides the whole word by the generator polynomial. Each accepted bit enters below the lowest stage, and the top stage feeds back through XOR taps set by the generator coefficients. When the bit marked last has been taken in, the register holds the remainder of the division. A zero remainder means the word is valid. Any other value means the word was corrupted.

The block reports a one-cycle `done` pulse together with `crc_error`, and the remainder stays visible on `syndrome`. A `start` pulse clears the block before each new word. The remainder can also be read out serially. Each `shift_out` cycle moves the top stage onto `syn_bit`, shifts the register up with a zero entering at the bottom, and uses no feedback.

With the default generator x^5+x^2+x+1, which contains the factor x+1, the check catches every odd-weight error pattern. It also catches every single burst of five bits or fewer.

Top module: `crc_rx_checker`

## Requirements
- R1: After reset, `syndrome` is 0, `done` is 0, `crc_error` is 0 and `syn_bit` is 0.
- R2: On each clock edge where `bit_valid` is high and `start` is low, the register becomes ((syndrome << 1) | bit_in) reduced modulo the generator. The generator is given as the low n coefficients `POLY_TAPS`, and the x^n term is implied. The default is n=5, generator 100111, taps 00111.
- R3: `done` is high for exactly the one cycle that follows the edge accepting a bit with `last` high. It is low in every other cycle, and `crc_error` is never high while `done` is low.
- R4: While `done` is high, `crc_error` is 1 exactly when `syndrome` is non-zero. With the default generator, the codeword 1000000011010 (13 bits) gives `syndrome` 0 and `crc_error` 0.
- R5: Inverting any single bit of a valid codeword makes `crc_error` 1.
- R6: Any error pattern with an odd number of inverted bits makes `crc_error` 1 (the default generator has x+1 as a factor).
- R7: Any single error burst of length 1 to n makes `crc_error` 1.
- R8: `start` has priority over `bit_valid`, `last` and `shift_out`. In the following cycle `syndrome`, `done`, `crc_error` and `syn_bit` are all 0, whatever the other inputs were.
- R9: On an edge with `shift_out` high and `start` and `bit_valid` low, `syn_bit` takes the old top bit of `syndrome`, and the register shifts up by one with a 0 entering bit 0 and no feedback. After n such cycles `syndrome` is 0. `shift_out` has no effect while `bit_valid` is high.
- R10: When `start`, `bit_valid` and `shift_out` are all low, `syndrome` and `syn_bit` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clears register and pending result |
| bit_valid | input | 1 | `bit_in` is accepted this cycle |
| bit_in | input | 1 | Received codeword bit, MSB first |
| last | input | 1 | Marks the final bit of the codeword |
| shift_out | input | 1 | Moves one remainder bit out serially |
| syndrome | output | WIDTH | Division register (remainder) |
| done | output | 1 | One-cycle pulse after the last bit |
| crc_error | output | 1 | Non-zero remainder, valid with `done` |
| syn_bit | output | 1 | Serially read-out remainder bit |

## Verification
The assertions assume that `last` means something only on cycles where `bit_valid` is high. They also assume that a read-out by `shift_out` is requested only between words, never while bits are arriving. The stimulus raises `last` only together with the final valid bit of each word. It inserts idle gaps inside words but starts read-outs only after `done`. The one exception is a deliberate collision cycle used to show that `shift_out` is overridden by `bit_valid`. Every word begins with a `start` pulse, and `start` is also driven on top of valid and last bits to exercise the priority rule.

// File: rtl/crcchk_pkg.sv
package crcchk_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_DIV   = 2'd2,
    OP_DRAIN = 2'd3
  } crc_op_e;

  // Priority: clear over divide over drain.
  function automatic crc_op_e pick_op(input logic clr, input logic take, input logic drain);
    if (clr)        return OP_CLEAR;
    else if (take)  return OP_DIV;
    else if (drain) return OP_DRAIN;
    else            return OP_HOLD;
  endfunction

endpackage

// File: rtl/crcchk_step.sv
module crcchk_step
  import crcchk_pkg::*;
#(
  parameter int WIDTH = 5,
  parameter logic [WIDTH-1:0] POLY_TAPS = 5'b00111
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             din,
  input  crc_op_e          op,
  output logic [WIDTH-1:0] nxt
);
  localparam int TOP = WIDTH - 1;

  logic             fb;
  logic             entry;
  logic [WIDTH-1:0] shifted;

  // Feedback only while dividing; the read-out path cuts it.
  assign fb    = cur[TOP] & (op == OP_DIV);
  assign entry = (op == OP_DIV) ? din : 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_low
      assign shifted[i] = entry ^ (POLY_TAPS[i] & fb);
    end else begin : g_up
      assign shifted[i] = cur[i-1] ^ (POLY_TAPS[i] & fb);
    end
  end

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_DIV,
      OP_DRAIN: nxt = shifted;
      default:  nxt = cur;
    endcase
  end

endmodule

// File: rtl/crcchk_result.sv
module crcchk_result
  import crcchk_pkg::*;
#(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  crc_op_e          op,
  input  logic             last,
  input  logic [WIDTH-1:0] nxt,
  output logic             done,
  output logic             crc_error
);
  logic finish;
  assign finish = (op == OP_DIV) && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      crc_error <= 1'b0;
    end else begin
      done      <= finish;
      crc_error <= finish && (nxt != '0);
    end
  end

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    finish |=> done); // R3
  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (rst)
    !finish |=> !done); // R3
  AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    crc_error |-> done); // R3

endmodule

// File: rtl/crc_rx_checker.sv
module crc_rx_checker
  import crcchk_pkg::*;
#(
  parameter int WIDTH = 5,
  parameter logic [WIDTH-1:0] POLY_TAPS = 5'b00111
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic             last,
  input  logic             shift_out,
  output logic [WIDTH-1:0] syndrome,
  output logic             done,
  output logic             crc_error,
  output logic             syn_bit
);
  localparam int TOP = WIDTH - 1;

  crc_op_e          op;
  logic [WIDTH-1:0] syn_q;
  logic [WIDTH-1:0] syn_d;
  logic             sbit_q;

  assign op = pick_op(start, bit_valid, shift_out);

  crcchk_step #(.WIDTH(WIDTH), .POLY_TAPS(POLY_TAPS)) i_step (
    .cur (syn_q),
    .din (bit_in),
    .op  (op),
    .nxt (syn_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      syn_q  <= '0;
      sbit_q <= 1'b0;
    end else begin
      syn_q <= syn_d;
      if (op == OP_CLEAR)      sbit_q <= 1'b0;
      else if (op == OP_DRAIN) sbit_q <= syn_q[TOP];
    end
  end

  crcchk_result #(.WIDTH(WIDTH)) i_result (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .last      (last),
    .nxt       (syn_d),
    .done      (done),
    .crc_error (crc_error)
  );

  assign syndrome = syn_q;
  assign syn_bit  = sbit_q;

  AST_FLAG_MATCHES_REM: assert property (@(posedge clk) disable iff (rst)
    done |-> (crc_error == (syn_q != '0))); // R4
  AST_START_WINS: assert property (@(posedge clk) disable iff (rst)
    start |=> (syn_q == '0) && !done && !sbit_q); // R8
  AST_DRAIN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (shift_out && !start && !bit_valid) |=> (sbit_q == $past(syn_q[TOP])) && !syn_q[0]); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!start && !bit_valid && !shift_out) |=> $stable(syn_q) && $stable(sbit_q)); // R10

endmodule

// File: tb/test_crc_rx_checker.sv
module test_crc_rx_checker;
  localparam int CLK_PERIOD = 10;
  localparam int W = 5;
  localparam int GEN = 'h27; // 100111

  logic clk = 1'b0;
  logic rst, start, bit_valid, bit_in, last, shift_out;
  logic [W-1:0] syndrome;
  logic done, crc_error, syn_bit;

  int vectors = 0;
  int fails = 0;
  int m_syn = 0, m_done = 0, m_err = 0, m_sbit = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_rx_checker #(.WIDTH(W), .POLY_TAPS(5'b00111)) i_crc_rx_checker (
    .clk(clk), .rst(rst), .start(start), .bit_valid(bit_valid), .bit_in(bit_in),
    .last(last), .shift_out(shift_out), .syndrome(syndrome), .done(done),
    .crc_error(crc_error), .syn_bit(syn_bit)
  );

  task automatic check(input int act, input int exp, input string tag);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    vectors++;
    if (int'(syndrome) != m_syn || int'(done) != m_done ||
        int'(crc_error) != m_err || int'(syn_bit) != m_sbit) begin
      fails++;
      $display("FAIL %s: actual syn=%0h done=%0d err=%0d sbit=%0d expected syn=%0h done=%0d err=%0d sbit=%0d",
               tag, syndrome, done, crc_error, syn_bit, m_syn, m_done, m_err, m_sbit);
    end
  endtask

  task automatic step(input logic s, input logic v, input logic b, input logic l,
                      input logic f, input string tag);
    start = s; bit_valid = v; bit_in = b; last = l; shift_out = f;
    if (s) begin
      m_syn = 0; m_done = 0; m_err = 0; m_sbit = 0;
    end else if (v) begin
      m_syn = (m_syn << 1) | int'(b);
      if ((m_syn & (1 << W)) != 0) m_syn = m_syn ^ GEN;
      m_done = int'(l);
      m_err = (l && m_syn != 0) ? 1 : 0;
    end else begin
      m_done = 0; m_err = 0;
      if (f) begin
        m_sbit = (m_syn >> (W-1)) & 1;
        m_syn = (m_syn << 1) & ((1 << W) - 1);
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  function automatic int rem_of(input longint word, input int len);
    int s = 0;
    for (int i = len - 1; i >= 0; i--) begin
      s = (s << 1) | int'((word >> i) & 1);
      if ((s & (1 << W)) != 0) s = s ^ GEN;
    end
    return s;
  endfunction

  function automatic longint encode(input longint msg, input int mlen);
    longint sh = msg << W;
    return sh | longint'(rem_of(sh, mlen + W));
  endfunction

  task automatic send_word(input longint w, input int len, input bit gaps, input string tag);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    for (int i = len - 1; i >= 0; i--) begin
      if (gaps && ($urandom % 3 == 0)) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
      step(1'b0, 1'b1, w[i], (i == 0), 1'b0, tag);
    end
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (R1..): actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    longint cw;
    int s_cap;
    rst = 1'b1; start = 0; bit_valid = 0; bit_in = 0; last = 0; shift_out = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    compare("R1 reset");

    // Known codeword
    check(rem_of(longint'(8'h80) << W, 13), 'b11010, "R2 fcs");
    send_word(13'b1000000011010, 13, 1'b0, "R4");
    check(done, 1, "R3 done");
    check(crc_error, 0, "R4 valid word");
    step(0, 0, 0, 0, 0, "R3");
    check(done, 0, "R3 one cycle");

    // Single-bit errors
    for (int p = 0; p < 13; p++) begin
      send_word(13'b1000000011010 ^ (longint'(1) << p), 13, 1'b0, "R5");
      check(crc_error, 1, "R5 single flip");
    end

    // Random valid words with idle gaps
    for (int k = 0; k < 20; k++) begin
      cw = encode(longint'($urandom & 16'hffff), 16);
      send_word(cw, 21, 1'b1, "R2");
      check(crc_error, 0, "R2 valid random");
    end

    // Odd-weight errors
    for (int k = 0; k < 15; k++) begin
      int a = $urandom % 21;
      int b = (a + 1 + $urandom % 19) % 21;
      int c;
      do c = $urandom % 21; while (c == a || c == b);
      cw = encode(longint'($urandom & 16'hffff), 16);
      cw = cw ^ (longint'(1) << a) ^ (longint'(1) << b) ^ (longint'(1) << c);
      send_word(cw, 21, 1'b0, "R6");
      check(crc_error, 1, "R6 triple flip");
    end

    // Bursts of length 1..W
    for (int len = 1; len <= W; len++) begin
      for (int k = 0; k < 4; k++) begin
        longint pat = longint'(1) | (longint'(1) << (len - 1)) |
                      longint'($urandom & ((1 << len) - 1));
        int off = $urandom % (21 - len + 1);
        cw = encode(longint'($urandom & 16'hffff), 16) ^ (pat << off);
        send_word(cw, 21, 1'b0, "R7");
        check(crc_error, 1, "R7 burst");
      end
    end

    // Start priority
    step(1, 0, 0, 0, 0, "R8");
    for (int i = 0; i < 6; i++) step(0, 1, 1'(i % 2), 0, 0, "R8");
    step(1, 1, 1, 1, 1, "R8");
    check(syndrome, 0, "R8 start clears");
    check(done, 0, "R8 start beats last");

    // Serial read-out
    send_word(13'b1000000011011, 13, 1'b0, "R9");
    check(crc_error, 1, "R9 prep");
    s_cap = syndrome;
    step(0, 0, 0, 0, 0, "R10");
    check(syndrome, s_cap, "R10 hold");
    for (int k = 0; k < W; k++) begin
      step(0, 0, 0, 0, 1, "R9");
      check(syn_bit, (s_cap >> (W - 1 - k)) & 1, "R9 serial bit");
    end
    check(syndrome, 0, "R9 drained");
    step(0, 1, 1, 0, 1, "R9 shift_out ignored");
    check(syndrome, 1, "R9 valid wins");

    finish_run();
  end

endmodule